// File: doc/BRIEF.md
# Rate-1/3 Parallel Concatenated Convolutional Encoder

This block turns one information block of N bits into a rate-1/3 turbo code word. It first collects the N bits into an internal buffer through a valid/ready bit input. A start-of-block pulse on the first bit carries the length N, which is set per block between 1 and `MAX_LEN`. It then runs two identical 8-state recursive systematic convolutional encoders side by side. The first reads the buffer in natural order. The second reads it in an order given by an external permutation table: the block presents index k and the table returns the permuted address one cycle later.

Each information position yields one 3-bit output symbol: the systematic bit and one parity bit from each encoder. When the data positions are done, both encoders are driven back to the all-zero state, three steps each. The resulting 12 tail bits leave as four more 3-bit symbols, the last of which carries the end-of-block flag. A block therefore always produces N+4 symbols, which is 3N+12 bits. The output has no backpressure.

Top module: `turbo_enc3`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `out_eob` and `perm_req_valid` are 0.
- R2: From idle, a handshake (`in_valid` and `in_ready`) with `in_sob`=1 stores bit 0 and takes N from `in_len`, with 1 <= N <= `MAX_LEN`. The next N-1 handshakes store bits 1 to N-1, and cycles with `in_valid`=0 store nothing. Handshakes in idle with `in_sob`=0 are discarded and do not change the next block's output.
- R3: Both encoder registers hold zero when the first data position of every block is encoded.
- R4: Each encoder has a 3-bit register s with s[0] the newest. With feedback f = s[1]^s[2], input x and a = x^f, the parity is a^s[0]^s[2] and the next state is {s[1],s[0],a}. Data symbol k holds bit 0 = u[k], bit 1 = parity of encoder 1 fed u[k], and bit 2 = parity of encoder 2 fed u[pi(k)].
- R5: After the last bit is loaded, the block shows `perm_req_valid`=1 with `perm_req_idx` = 0,1,...,N-1 on consecutive cycles. `perm_addr` must carry pi(k) in the cycle after index k is shown.
- R6: Data symbol k appears with `out_valid`=1 exactly 3 cycles after index k was shown on `perm_req_idx`, so the N data symbols occupy consecutive cycles.
- R7: Termination uses x = f for 3 steps per encoder, which leaves each register at zero. Each step yields the pair (x, parity). The first tail symbol appears 4 cycles after the last data symbol, and the tail symbols follow on consecutive cycles.
- R8: The tail bit sequence is t[0..11] = encoder 1 (x0,p0,x1,p1,x2,p2) followed by encoder 2 (x0,p0,x1,p1,x2,p2). Tail symbol j carries t[3j] in bit 0, t[3j+1] in bit 1 and t[3j+2] in bit 2.
- R9: A block of length N emits exactly N+4 symbols (3N+12 bits). `out_eob` is 1 on the last symbol only.
- R10: From the cycle after bit N-1 is accepted until `out_eob` is shown, `in_ready` is 0, so a start-of-block pulse in that time is ignored and the block being encoded is not disturbed.
- R11: `in_ready` is 1 again in the cycle that shows `out_eob`, so blocks can follow each other directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Block accepts input bits |
| in_sob | input | 1 | Marks the first bit of a block |
| in_len | input | LW | Block length N, sampled with the start bit |
| in_bit | input | 1 | Information bit |
| perm_req_valid | output | 1 | A permutation index is being requested |
| perm_req_idx | output | AW | Natural-order index k |
| perm_addr | input | AW | pi(k), one cycle after the request |
| out_valid | output | 1 | Output symbol is valid |
| out_sym | output | 3 | Coded symbol |
| out_eob | output | 1 | Last symbol of the block |

## Verification
The bench stamps every permutation request and every output symbol with the cycle in which it is seen. Index k must be requested at request cycle 0 plus k. Data symbol k is due 3 cycles after its request, and tail symbol j is due N+6+j cycles after the first request, since the last data symbol is followed by a 4-cycle gap. The bench's interleaver table model answers each request exactly one cycle later, which is the latency the design expects. `in_ready` is sampled in the very cycle that shows the end-of-block flag, and input is driven and output sampled on the falling edge, so every expected cycle is counted from the registers alone.

// File: rtl/te_pkg.sv
package te_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_TERM,
    ST_TAIL
  } enc_st_t;

  localparam int NUM_ENC    = 2;
  localparam int SYM_W      = 3;
  localparam int TAIL_STEPS = 3;
  localparam int TAIL_BITS  = 2 * NUM_ENC * TAIL_STEPS;
  localparam int TAIL_SYMS  = TAIL_BITS / SYM_W;
endpackage

// File: rtl/te_bitram.sv
module te_bitram #(
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/te_rsc.sv
module te_rsc (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       step,
  input  logic       term,
  input  logic       din,
  output logic       sys_o,
  output logic       par_o,
  output logic [2:0] state_o
);
  logic [2:0] sr;
  logic       fb, a_bit;
  logic [1:0] term_run;

  always_comb begin
    fb    = sr[1] ^ sr[2];
    sys_o = term ? fb : din;
    a_bit = sys_o ^ fb;
    par_o = a_bit ^ sr[0] ^ sr[2];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr       <= '0;
      term_run <= '0;
    end else if (step) begin
      sr <= {sr[1], sr[0], a_bit};
      if (!term)                term_run <= '0;
      else if (term_run != 2'd3) term_run <= term_run + 2'd1;
    end
  end

  assign state_o = sr;

  // R7: three flush steps leave the register empty
  assert_flush_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (term_run == 2'd3) |-> (sr == 3'b000));
endmodule

// File: rtl/turbo_enc3.sv
module turbo_enc3 #(
  parameter int MAX_LEN = 64,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int AW = $clog2(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sob,
  input  logic [LW-1:0] in_len,
  input  logic          in_bit,
  output logic          perm_req_valid,
  output logic [AW-1:0] perm_req_idx,
  input  logic [AW-1:0] perm_addr,
  output logic          out_valid,
  output logic [2:0]    out_sym,
  output logic          out_eob
);
  import te_pkg::*;

  enc_st_t st;
  logic [LW-1:0] blk_len, wcnt, rq;
  logic          issued;
  logic          s0_v, s0_first, s0_last;
  logic [AW-1:0] s0_k;
  logic          s1_v, s1_first, s1_last;
  logic [AW-1:0] s1_k;
  logic          s2_v, s2_first, s2_last;
  logic [1:0]    tcnt, ocnt;
  logic [TAIL_BITS-1:0] tail_bits;
  logic [3:0]    sym_base;
  logic [LW:0]   sym_cnt;

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr [NUM_ENC];
  logic          rd_bit  [NUM_ENC];
  logic          enc_x   [NUM_ENC];
  logic          enc_p   [NUM_ENC];
  logic [2:0]    enc_s   [NUM_ENC];
  logic          enc_step, enc_term, enc_clr;

  assign in_ready = (st == ST_IDLE) || (st == ST_LOAD);
  assign wr_en    = in_valid && in_ready && ((st == ST_LOAD) || in_sob);
  assign wr_addr  = (st == ST_IDLE) ? '0 : wcnt[AW-1:0];
  assign rd_addr[0] = s1_k;
  assign rd_addr[1] = perm_addr;
  assign enc_step = s2_v || (st == ST_TERM);
  assign enc_term = (st == ST_TERM);
  assign enc_clr  = (st == ST_IDLE);
  assign sym_base = 4'(ocnt) * 4'd3;

  generate
    for (genvar i = 0; i < NUM_ENC; i++) begin : g_enc
      te_bitram #(.AW(AW)) u_buf (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (in_bit),
        .raddr (rd_addr[i]),
        .rdata (rd_bit[i])
      );
      te_rsc u_rsc (
        .clk     (clk),
        .rst     (rst),
        .clr     (enc_clr),
        .step    (enc_step),
        .term    (enc_term),
        .din     (rd_bit[i]),
        .sys_o   (enc_x[i]),
        .par_o   (enc_p[i]),
        .state_o (enc_s[i])
      );
    end
  endgenerate

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      blk_len   <= '0;
      wcnt      <= '0;
      rq        <= '0;
      issued    <= 1'b0;
      tcnt      <= '0;
      ocnt      <= '0;
      tail_bits <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          rq     <= '0;
          issued <= 1'b0;
          if (in_valid && in_sob) begin
            blk_len <= in_len;
            wcnt    <= LW'(1);
            st      <= (in_len == LW'(1)) ? ST_RUN : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            wcnt <= wcnt + LW'(1);
            if (wcnt == blk_len - LW'(1)) st <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!issued) begin
            rq <= rq + LW'(1);
            if (rq == blk_len - LW'(1)) issued <= 1'b1;
          end
          if (s2_v && s2_last) begin
            st   <= ST_TERM;
            tcnt <= '0;
          end
        end
        ST_TERM: begin
          tail_bits[{tcnt, 1'b0} +: 2]                <= {enc_p[0], enc_x[0]};
          tail_bits[4'd6 + {1'b0, tcnt, 1'b0} +: 2]   <= {enc_p[1], enc_x[1]};
          tcnt <= tcnt + 2'd1;
          if (tcnt == 2'd2) begin
            st   <= ST_TAIL;
            ocnt <= '0;
          end
        end
        ST_TAIL: begin
          ocnt <= ocnt + 2'd1;
          if (ocnt == 2'd3) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // request / read pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      s0_v <= 1'b0; s0_k <= '0; s0_first <= 1'b0; s0_last <= 1'b0;
      s1_v <= 1'b0; s1_k <= '0; s1_first <= 1'b0; s1_last <= 1'b0;
      s2_v <= 1'b0; s2_first <= 1'b0; s2_last <= 1'b0;
    end else begin
      s0_v     <= (st == ST_RUN) && !issued;
      s0_k     <= rq[AW-1:0];
      s0_first <= (rq == '0);
      s0_last  <= (rq == blk_len - LW'(1));
      s1_v     <= s0_v;
      s1_k     <= s0_k;
      s1_first <= s0_first;
      s1_last  <= s0_last;
      s2_v     <= s1_v;
      s2_first <= s1_first;
      s2_last  <= s1_last;
    end
  end

  assign perm_req_valid = s0_v;
  assign perm_req_idx   = s0_k;

  // registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_eob   <= 1'b0;
      sym_cnt   <= '0;
    end else begin
      out_valid <= s2_v || (st == ST_TAIL);
      out_sym   <= s2_v ? {enc_p[1], enc_p[0], enc_x[0]} : tail_bits[sym_base +: 3];
      out_eob   <= (st == ST_TAIL) && (ocnt == 2'd3);
      if (out_valid) sym_cnt <= out_eob ? '0 : sym_cnt + (LW+1)'(1);
    end
  end

  // R3: each block starts from empty registers
  assert_clean_start_R3: assert property (@(posedge clk) disable iff (rst)
    (s2_v && s2_first) |-> ((enc_s[0] == 3'b000) && (enc_s[1] == 3'b000)));
  // R5: requested indices step by one
  assert_req_order_R5: assert property (@(posedge clk) disable iff (rst)
    (s0_v && $past(s0_v)) |-> (s0_k == $past(s0_k) + AW'(1)));
  // R9: N+4 symbols per block, flag only with data
  assert_block_len_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eob) |-> (sym_cnt == {1'b0, blk_len} + (LW+1)'(3)));
  assert_eob_valid_R9: assert property (@(posedge clk) disable iff (rst)
    out_eob |-> out_valid);
  // R10: no input accepted while symbols are still leaving
  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eob) |-> !in_ready);
endmodule

// File: tb/turbo_enc3_test.sv
module turbo_enc3_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 16;
  localparam int LW = $clog2(MAXN + 1);
  localparam int AW = $clog2(MAXN);
  localparam int CAP = MAXN + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sob = 1'b0, in_bit = 1'b0;
  logic [LW-1:0] in_len = '0;
  logic in_ready, perm_req_valid, out_valid, out_eob;
  logic [AW-1:0] perm_req_idx;
  logic [AW-1:0] perm_addr = '0;
  logic [2:0] out_sym;

  turbo_enc3 #(.MAX_LEN(MAXN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sob(in_sob), .in_len(in_len), .in_bit(in_bit),
    .perm_req_valid(perm_req_valid), .perm_req_idx(perm_req_idx),
    .perm_addr(perm_addr), .out_valid(out_valid), .out_sym(out_sym),
    .out_eob(out_eob)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int pi_tab [MAXN];
  always @(posedge clk) perm_addr <= AW'(pi_tab[perm_req_idx]);

  logic [2:0] got_sym [CAP];
  int         got_cyc [CAP];
  bit         got_eob [CAP];
  int         rq_idx  [CAP];
  int         rq_cyc  [CAP];
  int gcnt = 0, rcnt = 0;
  bit eob_seen = 0, ready_at_eob = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (gcnt < CAP) begin
          got_sym[gcnt] = out_sym;
          got_cyc[gcnt] = cyc;
          got_eob[gcnt] = out_eob;
        end
        gcnt++;
        if (out_eob) begin
          eob_seen = 1;
          ready_at_eob = in_ready;
        end
      end
      if (perm_req_valid) begin
        if (rcnt < CAP) begin
          rq_idx[rcnt] = int'(perm_req_idx);
          rq_cyc[rcnt] = cyc;
        end
        rcnt++;
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void rstep(inout logic [2:0] r, input bit b, input bit tm,
                                output bit x, output bit p);
    bit f, a;
    f = r[1] ^ r[2];
    x = tm ? f : b;
    a = x ^ f;
    p = a ^ r[0] ^ r[2];
    r = {r[1], r[0], a};
  endfunction

  function automatic int gcd(int a, int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic run_block(int n, int pat, int pstyle, bit poke_busy, bit junk_idle);
    bit u [MAXN];
    logic [2:0] expv [CAP];
    bit t [12];
    logic [2:0] r1, r2;
    bit x, p1, p2, xd;
    logic [7:0] v;
    int s, guard;

    v = 8'h5A ^ 8'(n * 7 + pat);
    for (int k = 0; k < n; k++) begin
      case (pat)
        0: u[k] = 1'b0;
        1: u[k] = 1'b1;
        default: begin
          u[k] = v[0];
          v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
        end
      endcase
    end
    s = 3;
    while (gcd(s, n) != 1) s++;
    for (int k = 0; k < n; k++) begin
      case (pstyle)
        0: pi_tab[k] = n - 1 - k;
        1: pi_tab[k] = (s * k + n / 2) % n;
        default: pi_tab[k] = k;
      endcase
    end

    r1 = '0; r2 = '0;
    for (int k = 0; k < n; k++) begin
      rstep(r1, u[k], 1'b0, x, p1);
      rstep(r2, u[pi_tab[k]], 1'b0, xd, p2);
      expv[k] = {p2, p1, u[k]};
    end
    for (int j = 0; j < 3; j++) begin
      rstep(r1, 1'b0, 1'b1, x, p1);
      t[2*j] = x; t[2*j+1] = p1;
      rstep(r2, 1'b0, 1'b1, x, p2);
      t[6+2*j] = x; t[6+2*j+1] = p2;
    end
    for (int j = 0; j < 4; j++) expv[n+j] = {t[3*j+2], t[3*j+1], t[3*j]};

    @(negedge clk);
    gcnt = 0; rcnt = 0; eob_seen = 0; ready_at_eob = 0;

    if (junk_idle) begin
      for (int j = 0; j < 3; j++) begin
        in_valid = 1'b1; in_sob = 1'b0; in_bit = 1'(j); in_len = LW'(1);
        @(negedge clk);
      end
    end

    for (int k = 0; k < n; k++) begin
      if (pat == 2 && (k % 3) == 1) begin
        in_valid = 1'b0; in_sob = 1'b0; in_bit = ~u[k];
        @(negedge clk);
      end
      in_valid = 1'b1; in_sob = (k == 0); in_bit = u[k]; in_len = LW'(n);
      check(in_ready == 1'b1, "R2", "ready while loading", int'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sob = 1'b0;

    if (poke_busy) begin
      for (int j = 0; j < 4; j++) begin
        in_valid = 1'b1; in_sob = 1'b1; in_len = LW'(1); in_bit = 1'b1;
        check(in_ready == 1'b0, "R10", "ready while busy", int'(in_ready), 0);
        @(negedge clk);
      end
      in_valid = 1'b0; in_sob = 1'b0;
    end

    guard = 0;
    while (!eob_seen && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "no symbol after eob", int'(out_valid), 0);
    check(ready_at_eob == 1'b1, "R11", "ready at eob", int'(ready_at_eob), 1);
    check(gcnt == n + 4, "R9", "symbol count", gcnt, n + 4);
    check(rcnt == n, "R5", "request count", rcnt, n);
    if (gcnt == n + 4 && rcnt == n) begin
      for (int k = 0; k < n; k++) begin
        check(rq_idx[k] == k, "R5", "request index", rq_idx[k], k);
        check(rq_cyc[k] == rq_cyc[0] + k, "R5", "request cycle", rq_cyc[k], rq_cyc[0] + k);
        check(got_cyc[k] == rq_cyc[0] + 3 + k, "R6", "data symbol cycle",
              got_cyc[k], rq_cyc[0] + 3 + k);
        check(got_sym[k] == expv[k], "R3/R4", "data symbol", int'(got_sym[k]), int'(expv[k]));
        check(got_eob[k] == 1'b0, "R9", "eob on data", int'(got_eob[k]), 0);
      end
      for (int j = 0; j < 4; j++) begin
        check(got_cyc[n+j] == rq_cyc[0] + n + 6 + j, "R7", "tail symbol cycle",
              got_cyc[n+j], rq_cyc[0] + n + 6 + j);
        check(got_sym[n+j] == expv[n+j], "R8", "tail symbol",
              int'(got_sym[n+j]), int'(expv[n+j]));
        check(got_eob[n+j] == (j == 3), "R9", "eob placement", int'(got_eob[n+j]), int'(j == 3));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    check(out_eob == 1'b0, "R1", "reset out_eob", int'(out_eob), 0);
    check(perm_req_valid == 1'b0, "R1", "reset perm_req_valid", int'(perm_req_valid), 0);
    for (int n = 1; n <= MAXN; n++)
      for (int pat = 0; pat < 3; pat++)
        run_block(n, pat, (n + pat) % 3, pat == 1, pat == 2);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog R9: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule